// File: doc/BRIEF.md
# Quadword Load/Store Access Unit

This unit sits beside the word memory path of a 32-bit MIPS-like integer core and executes its memory instructions: a plain word load and store, a 64-bit doubleword store and the 128-bit quadword load and store. The core hands it one instruction at a time together with the value of the base register and the value of the source register. The unit forms the effective address, checks the alignment the access size demands, and then either raises an address-error exception or drives a word-wide memory port.

Registers in the core are only 32 bits wide. A quadword load is therefore reduced to one word read of the lowest word of the quadword, travelling the same request-then-wait route as a word load. A quadword or doubleword store becomes a counted sequence of word writes at ascending addresses. The first beat carries the register value and the upper beats carry zero. Read data comes back to the register file through a one-cycle writeback pulse. Register 0 is never written.

The instruction input and the memory request port are valid/ready streams. The core may hold `ins_valid` high as long as it likes, and an instruction is taken on a clock edge where `ins_valid` and `ins_ready` are both high. The memory may hold `mreq_ready` low for any number of cycles. While it does, the request (valid, address, write enable and data) stays unchanged. A write completes on its handshake edge. A read answers with a single-cycle `mrsp_valid` pulse at some later cycle, and that pulse cannot be back-pressured. Writeback, exception and `busy` are plain outputs.

Top module: `qmem_unit`

## Requirements
- R1: The instruction word has the opcode in [31:26], the base register in [25:21], the data register in [20:16] and a signed offset in [15:0]. Word load is 0x23, word store 0x2B, quad load 0x1E, quad store 0x1F and doubleword store 0x3F, so a quad load of register 9 from base 5 with offset 0 encodes as 0x78A90000. The effective address is `ins_base` plus the sign-extended offset.
- R2: An access whose effective address is misaligned for its size faults instead of touching memory. The low 4 bits must be zero for quad accesses, the low 3 bits for the doubleword store and the low 2 bits for word accesses. On a fault `exc_valid` pulses for one cycle, in the cycle after the instruction is taken, with `exc_addr` set to the effective address. No memory request follows.
- R3: A faulting load (word or quad) reports `exc_code` 4, and a faulting store reports `exc_code` 5.
- R4: An aligned quad load issues exactly one read, at the effective address. In the cycle after the read response, `wb_en` pulses with `wb_idx` set to the data register and `wb_data` set to the returned word.
- R5: A quad load writes back the same value a word load at the same address does.
- R6: A quad load never writes memory. All four words of the addressed quadword keep their values.
- R7: An aligned quad store performs four write beats at EA, EA+4, EA+8 and EA+12, in that order. The first beat carries `ins_rtval` and the other three carry zero.
- R8: An aligned doubleword store performs two write beats at EA and EA+4, carrying `ins_rtval` and then zero. A word store performs one beat at EA.
- R9: `busy` is high from the cycle after a memory instruction is taken until the final write handshake or the read response. `ins_ready` is low whenever `busy` is high.
- R10: A load into register 0 produces no writeback pulse.
- R11: While `mreq_valid` is high and `mreq_ready` is low, the request's address, write enable and data hold their values in the next cycle.
- R12: An instruction with any other opcode is taken and has no effect. It produces no request, no writeback and no exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Instruction offered |
| ins_ready | output | 1 | Unit can take an instruction |
| ins_word | input | 32 | Instruction word |
| ins_base | input | DATA_W | Value of the base register |
| ins_rtval | input | DATA_W | Value of the data register (store source) |
| mreq_valid | output | 1 | Memory request valid |
| mreq_ready | input | 1 | Memory accepts the request |
| mreq_we | output | 1 | 1 = write, 0 = read |
| mreq_addr | output | DATA_W | Byte address of the word |
| mreq_wdata | output | DATA_W | Write data |
| mrsp_valid | input | 1 | Read data valid (one-cycle pulse) |
| mrsp_data | input | DATA_W | Read data |
| wb_en | output | 1 | Register writeback pulse |
| wb_idx | output | 5 | Destination register |
| wb_data | output | DATA_W | Writeback value |
| exc_valid | output | 1 | Address-error pulse |
| exc_code | output | 5 | 4 = load fault, 5 = store fault |
| exc_addr | output | DATA_W | Faulting effective address |
| busy | output | 1 | Memory operation in progress |

## Verification
The bench targets the boundary between the alignment classes. A doubleword store at an address that is 8 modulo 16 must succeed, while a quad store there must fault. A design that shares one mask across the sizes would either fault the doubleword or let the quad through. Quad loads are compared against a word load at the same address, with four distinct words preloaded around it. A design that picked the wrong lane, or wrote during a load, would show a wrong writeback or a changed neighbouring word. Random memory back-pressure exercises beat ordering and request stability: a counter that skipped or repeated a beat, or an address that moved while the memory was stalled, would leave the wrong words in memory. Loads into register 0, unknown opcodes and the load-versus-store fault codes are covered both directed and at random.

// File: rtl/qmem_pkg.sv
package qmem_pkg;
  localparam logic [5:0] OPC_LW = 6'h23;
  localparam logic [5:0] OPC_SW = 6'h2B;
  localparam logic [5:0] OPC_LQ = 6'h1E;
  localparam logic [5:0] OPC_SQ = 6'h1F;
  localparam logic [5:0] OPC_SD = 6'h3F;

  localparam logic [4:0] EXC_ADDR_LOAD  = 5'd4;
  localparam logic [4:0] EXC_ADDR_STORE = 5'd5;

  typedef enum logic [2:0] {
    K_NONE, K_LOADW, K_LOADQ, K_STOREW, K_STORED, K_STOREQ
  } kind_e;
endpackage

// File: rtl/qmem_decode.sv
module qmem_decode
  import qmem_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int QUAD_BEATS  = 4,
  parameter int DWORD_BEATS = 2,
  parameter int CNT_W       = 2
) (
  input  logic [31:0]       instr,
  input  logic [DATA_W-1:0] base_val,
  output kind_e             kind,
  output logic [4:0]        rt_idx,
  output logic [DATA_W-1:0] ea,
  output logic              bad_align,
  output logic [4:0]        fault_code,
  output logic [CNT_W-1:0]  last_beat
);
  localparam int BYTES = DATA_W / 8;
  localparam logic [DATA_W-1:0] WMASK = DATA_W'(BYTES - 1);
  localparam logic [DATA_W-1:0] DMASK = DATA_W'(DWORD_BEATS * BYTES - 1);
  localparam logic [DATA_W-1:0] QMASK = DATA_W'(QUAD_BEATS * BYTES - 1);

  logic [5:0]        opc;
  logic [DATA_W-1:0] mask;
  logic              is_store;
  logic              unused_rs;

  assign opc       = instr[31:26];
  assign unused_rs = ^instr[25:21];

  always_comb begin
    ea     = base_val + {{(DATA_W-16){instr[15]}}, instr[15:0]};
    rt_idx = instr[20:16];
    case (opc)
      OPC_LW:  kind = K_LOADW;
      OPC_LQ:  kind = K_LOADQ;
      OPC_SW:  kind = K_STOREW;
      OPC_SD:  kind = K_STORED;
      OPC_SQ:  kind = K_STOREQ;
      default: kind = K_NONE;
    endcase
    case (kind)
      K_LOADW, K_STOREW: mask = WMASK;
      K_STORED:          mask = DMASK;
      K_LOADQ, K_STOREQ: mask = QMASK;
      default:           mask = '0;
    endcase
    is_store   = (kind == K_STOREW) || (kind == K_STORED) || (kind == K_STOREQ);
    bad_align  = (ea & mask) != '0;
    fault_code = is_store ? EXC_ADDR_STORE : EXC_ADDR_LOAD;
    case (kind)
      K_STOREQ: last_beat = CNT_W'(QUAD_BEATS - 1);
      K_STORED: last_beat = CNT_W'(DWORD_BEATS - 1);
      default:  last_beat = '0;
    endcase
  end
endmodule

// File: rtl/qmem_beat_ctr.sv
module qmem_beat_ctr #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] last_in,
  input  logic             step,
  output logic [CNT_W-1:0] beat,
  output logic             final_beat
);
  logic [CNT_W-1:0] last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beat   <= '0;
      last_q <= '0;
    end else if (start) begin
      beat   <= '0;
      last_q <= last_in;
    end else if (step) begin
      beat <= beat + 1'b1;
    end
  end

  assign final_beat = (beat == last_q);
endmodule

// File: rtl/qmem_wb.sv
module qmem_wb #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [4:0]        idx,
  input  logic [DATA_W-1:0] data,
  output logic              wb_en,
  output logic [4:0]        wb_idx,
  output logic [DATA_W-1:0] wb_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb_en   <= 1'b0;
      wb_idx  <= '0;
      wb_data <= '0;
    end else begin
      wb_en <= fire && (idx != 5'd0);
      if (fire) begin
        wb_idx  <= idx;
        wb_data <= data;
      end
    end
  end
endmodule

// File: rtl/qmem_unit.sv
module qmem_unit
  import qmem_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int QUAD_BEATS  = 4,
  parameter int DWORD_BEATS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_valid,
  output logic              ins_ready,
  input  logic [31:0]       ins_word,
  input  logic [DATA_W-1:0] ins_base,
  input  logic [DATA_W-1:0] ins_rtval,
  output logic              mreq_valid,
  input  logic              mreq_ready,
  output logic              mreq_we,
  output logic [DATA_W-1:0] mreq_addr,
  output logic [DATA_W-1:0] mreq_wdata,
  input  logic              mrsp_valid,
  input  logic [DATA_W-1:0] mrsp_data,
  output logic              wb_en,
  output logic [4:0]        wb_idx,
  output logic [DATA_W-1:0] wb_data,
  output logic              exc_valid,
  output logic [4:0]        exc_code,
  output logic [DATA_W-1:0] exc_addr,
  output logic              busy
);
  localparam int CNT_W = (QUAD_BEATS > 1) ? $clog2(QUAD_BEATS) : 1;
  localparam int BYTES = DATA_W / 8;
  localparam int BSH   = $clog2(BYTES);

  typedef enum logic [1:0] {ST_IDLE, ST_RD_REQ, ST_RD_WAIT, ST_WR} st_e;
  st_e st_q, st_d;

  kind_e             dec_kind;
  logic [4:0]        dec_rt;
  logic [DATA_W-1:0] dec_ea;
  logic              dec_bad;
  logic [4:0]        dec_code;
  logic [CNT_W-1:0]  dec_last;

  logic              accept;
  logic [DATA_W-1:0] ea_q;
  logic [DATA_W-1:0] rtval_q;
  logic [4:0]        rt_q;
  logic [CNT_W-1:0]  beat;
  logic              final_beat;
  logic              wr_step;
  logic              rd_fire;

  qmem_decode #(
    .DATA_W(DATA_W), .QUAD_BEATS(QUAD_BEATS),
    .DWORD_BEATS(DWORD_BEATS), .CNT_W(CNT_W)
  ) u_dec (
    .instr(ins_word), .base_val(ins_base), .kind(dec_kind), .rt_idx(dec_rt),
    .ea(dec_ea), .bad_align(dec_bad), .fault_code(dec_code), .last_beat(dec_last)
  );

  assign busy      = (st_q != ST_IDLE);
  assign ins_ready = !busy;
  assign accept    = ins_valid && ins_ready;

  qmem_beat_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .start(accept), .last_in(dec_last),
    .step(wr_step), .beat(beat), .final_beat(final_beat)
  );

  assign mreq_valid = (st_q == ST_RD_REQ) || (st_q == ST_WR);
  assign mreq_we    = (st_q == ST_WR);
  assign mreq_addr  = ea_q + ({{(DATA_W-CNT_W){1'b0}}, beat} << BSH);
  assign mreq_wdata = (beat == '0) ? rtval_q : '0;
  assign wr_step    = (st_q == ST_WR) && mreq_ready;
  assign rd_fire    = (st_q == ST_RD_WAIT) && mrsp_valid;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: begin
        if (accept && !dec_bad) begin
          case (dec_kind)
            K_LOADW, K_LOADQ:            st_d = ST_RD_REQ;
            K_STOREW, K_STORED, K_STOREQ: st_d = ST_WR;
            default:                     st_d = ST_IDLE;
          endcase
        end
      end
      ST_RD_REQ:  if (mreq_ready) st_d = ST_RD_WAIT;
      ST_RD_WAIT: if (mrsp_valid) st_d = ST_IDLE;
      ST_WR:      if (mreq_ready && final_beat) st_d = ST_IDLE;
      default:    st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      ea_q      <= '0;
      rtval_q   <= '0;
      rt_q      <= '0;
      exc_valid <= 1'b0;
      exc_code  <= '0;
      exc_addr  <= '0;
    end else begin
      st_q      <= st_d;
      exc_valid <= accept && dec_bad;
      if (accept) begin
        ea_q    <= dec_ea;
        rtval_q <= ins_rtval;
        rt_q    <= dec_rt;
      end
      if (accept && dec_bad) begin
        exc_code <= dec_code;
        exc_addr <= dec_ea;
      end
    end
  end

  qmem_wb #(.DATA_W(DATA_W)) u_wb (
    .clk(clk), .rst_n(rst_n), .fire(rd_fire), .idx(rt_q), .data(mrsp_data),
    .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data)
  );
endmodule

// File: rtl/qmem_unit_chk.sv
module qmem_unit_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ins_valid,
  input logic              ins_ready,
  input logic              mreq_valid,
  input logic              mreq_ready,
  input logic              mreq_we,
  input logic [DATA_W-1:0] mreq_addr,
  input logic [DATA_W-1:0] mreq_wdata,
  input logic              mrsp_valid,
  input logic              wb_en,
  input logic [4:0]        wb_idx,
  input logic              exc_valid,
  input logic [4:0]        exc_code,
  input logic              busy
);
  localparam int BYTES = DATA_W / 8;

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mreq_valid && !mreq_ready) |=> (mreq_valid && $stable(mreq_addr)
                                     && $stable(mreq_we) && $stable(mreq_wdata)));

  assert_req_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid |-> (busy && !ins_ready));

  assert_no_req_on_fault_R2: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> !mreq_valid);

  assert_word_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid |-> (mreq_addr[1:0] == 2'b00));

  assert_fault_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> (exc_code == 5'd4 || exc_code == 5'd5));

  assert_no_r0_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (wb_idx != 5'd0));

  assert_wb_after_rsp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> $past(mrsp_valid));

  assert_beat_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mreq_valid && mreq_ready && mreq_we) ##1 (mreq_valid && mreq_we)
      |-> (mreq_addr == $past(mreq_addr) + DATA_W'(BYTES) && mreq_wdata == '0));

  logic unused_iv;
  assign unused_iv = ins_valid;
endmodule

bind qmem_unit qmem_unit_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/qmem_unit_tb.sv
`timescale 1ns/1ps
module qmem_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ins_valid = 1'b0;
  logic        ins_ready;
  logic [31:0] ins_word = '0, ins_base = '0, ins_rtval = '0;
  logic        mreq_valid, mreq_ready, mreq_we;
  logic [31:0] mreq_addr, mreq_wdata;
  logic        mrsp_valid;
  logic [31:0] mrsp_data;
  logic        wb_en;
  logic [4:0]  wb_idx;
  logic [31:0] wb_data;
  logic        exc_valid;
  logic [4:0]  exc_code;
  logic [31:0] exc_addr;
  logic        busy;

  always #10 clk = ~clk;

  qmem_unit u_dut (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(ins_ready),
    .ins_word(ins_word), .ins_base(ins_base), .ins_rtval(ins_rtval),
    .mreq_valid(mreq_valid), .mreq_ready(mreq_ready), .mreq_we(mreq_we),
    .mreq_addr(mreq_addr), .mreq_wdata(mreq_wdata), .mrsp_valid(mrsp_valid),
    .mrsp_data(mrsp_data), .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data),
    .exc_valid(exc_valid), .exc_code(exc_code), .exc_addr(exc_addr), .busy(busy)
  );

  logic [31:0] mem [64];
  logic [31:0] snap [64];
  int n_rd = 0, n_wr = 0, n_wb = 0, n_exc = 0, n_busy = 0, n_conflict = 0, n_hold_err = 0;
  logic [31:0] rd_addr, last_wb_data, last_exc_addr;
  logic [4:0]  last_wb_idx, last_exc_code;
  logic [31:0] wr_addr_log [16];
  logic [31:0] wr_data_log [16];
  logic        prev_stall = 1'b0;
  logic [31:0] prev_addr;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  // memory model, random back-pressure and port monitor
  always @(posedge clk) begin
    if (!rst_n) begin
      mrsp_valid <= 1'b0;
      mrsp_data  <= '0;
      mreq_ready <= 1'b0;
      prev_stall <= 1'b0;
    end else begin
      mrsp_valid <= mreq_valid && mreq_ready && !mreq_we;
      if (mreq_valid && mreq_ready && !mreq_we) begin
        mrsp_data <= mem[mreq_addr[7:2]];
        rd_addr   <= mreq_addr;
        n_rd      <= n_rd + 1;
      end
      if (mreq_valid && mreq_ready && mreq_we) begin
        mem[mreq_addr[7:2]]   <= mreq_wdata;
        wr_addr_log[n_wr%16]  <= mreq_addr;
        wr_data_log[n_wr%16]  <= mreq_wdata;
        n_wr                  <= n_wr + 1;
      end
      mreq_ready <= ($urandom % 4) != 0;
      if (wb_en) begin
        n_wb <= n_wb + 1; last_wb_idx <= wb_idx; last_wb_data <= wb_data;
      end
      if (exc_valid) begin
        n_exc <= n_exc + 1; last_exc_code <= exc_code; last_exc_addr <= exc_addr;
      end
      if (busy) n_busy <= n_busy + 1;
      if (busy && ins_ready) n_conflict <= n_conflict + 1;
      if (prev_stall && !(mreq_valid && mreq_addr == prev_addr)) n_hold_err <= n_hold_err + 1;
      prev_stall <= mreq_valid && !mreq_ready;
      prev_addr  <= mreq_addr;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%08h expected=%08h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc(input logic [5:0] op, input logic [4:0] rs,
                                      input logic [4:0] rt, input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  function automatic logic [31:0] align_mask(input logic [5:0] op);
    case (op)
      6'h1E, 6'h1F: return 32'hF;
      6'h3F:        return 32'h7;
      6'h23, 6'h2B: return 32'h3;
      default:      return 32'h0;
    endcase
  endfunction

  function automatic int beats_of(input logic [5:0] op);
    case (op)
      6'h1F: return 4;
      6'h3F: return 2;
      6'h2B: return 1;
      default: return 0;
    endcase
  endfunction

  task automatic run_op(input logic [5:0] op, input logic [4:0] rt, input logic [15:0] imm,
                        input logic [31:0] base, input logic [31:0] rtv);
    logic [31:0] ea;
    int rd0, wr0, wb0, exc0, busy0;
    bit is_load, is_store, bad;
    ea = base + {{16{imm[15]}}, imm};
    for (int i = 0; i < 64; i++) snap[i] = mem[i];
    rd0 = n_rd; wr0 = n_wr; wb0 = n_wb; exc0 = n_exc; busy0 = n_busy;
    @(negedge clk);
    ins_word = enc(op, 5'd5, rt, imm); ins_base = base; ins_rtval = rtv; ins_valid = 1'b1;
    while (!ins_ready) @(negedge clk);
    @(negedge clk);
    ins_valid = 1'b0;
    while (busy) @(negedge clk);
    @(negedge clk);
    is_load  = (op == 6'h23) || (op == 6'h1E);
    is_store = beats_of(op) != 0;
    bad      = (ea & align_mask(op)) != 0;
    if (!is_load && !is_store) begin
      chk(n_rd == rd0 && n_wr == wr0, "R12", "unknown opcode memory traffic", n_rd + n_wr, rd0 + wr0);
      chk(n_wb == wb0 && n_exc == exc0, "R12", "unknown opcode wb/exc", n_wb + n_exc, wb0 + exc0);
    end else if (bad) begin
      chk(n_exc == exc0 + 1 && last_exc_addr == ea, "R2", "fault address", last_exc_addr, ea);
      chk(n_rd == rd0 && n_wr == wr0, "R2", "no access on fault", n_rd + n_wr, rd0 + wr0);
      chk(last_exc_code == (is_load ? 5'd4 : 5'd5), "R3", "fault code",
          32'(last_exc_code), is_load ? 32'd4 : 32'd5);
    end else if (is_load) begin
      chk(n_rd == rd0 + 1 && rd_addr == ea, "R4", "single read at EA", rd_addr, ea);
      if (rt == 5'd0) begin
        chk(n_wb == wb0, "R10", "r0 writeback discarded", n_wb, wb0);
      end else begin
        chk(n_wb == wb0 + 1 && last_wb_idx == rt, "R4", "writeback index", 32'(last_wb_idx), 32'(rt));
        chk(last_wb_data == snap[ea[7:2]], "R5", "load value", last_wb_data, snap[ea[7:2]]);
      end
      if (op == 6'h1E) begin
        bit same = 1'b1;
        for (int i = 0; i < 64; i++) if (mem[i] != snap[i]) same = 1'b0;
        chk(same && n_wr == wr0, "R6", "quad load left memory unchanged", n_wr, wr0);
      end
    end else begin
      int nb = beats_of(op);
      chk(n_wr == wr0 + nb, (nb == 4) ? "R7" : "R8", "write beat count", n_wr - wr0, nb);
      chk(n_busy - busy0 >= nb, "R9", "busy spans beats", n_busy - busy0, nb);
      for (int i = 0; i < nb; i++) begin
        logic [31:0] a = ea + 32'(4 * i);
        logic [31:0] d = (i == 0) ? rtv : 32'h0;
        chk(wr_addr_log[(wr0 + i) % 16] == a, (nb == 4) ? "R7" : "R8", "beat address",
            wr_addr_log[(wr0 + i) % 16], a);
        chk(mem[a[7:2]] == d, (nb == 4) ? "R7" : "R8", "beat data", mem[a[7:2]], d);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R9 watchdog expired actual=%08h expected=%08h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    for (int i = 0; i < 64; i++) mem[i] = 32'h1000_0000 + 32'(i * 32'h0101);
    repeat (3) @(negedge clk);
    chk(!busy && ins_ready && !mreq_valid && !wb_en && !exc_valid, "R9", "reset state",
        {busy, ins_ready, mreq_valid, wb_en, exc_valid}, 32'h08);
    rst_n = 1'b1;
    @(negedge clk);

    chk(enc(6'h1E, 5'd5, 5'd9, 16'h0) == 32'h78A90000, "R1", "quad load encoding",
        enc(6'h1E, 5'd5, 5'd9, 16'h0), 32'h78A90000);
    mem[16] = 32'hAABBCCDD; mem[17] = 32'h11112222; mem[18] = 32'h33334444; mem[19] = 32'h55556666;
    run_op(6'h1E, 5'd9, 16'h0000, 32'h40, 32'h0);        // R4 R5 R6 aligned quad load
    run_op(6'h23, 5'd10, 16'h0000, 32'h40, 32'h0);       // R5 word load same EA
    run_op(6'h1E, 5'd9, 16'hFFF8, 32'h48, 32'h0);        // R1 negative offset back to 0x40
    run_op(6'h1E, 5'd0, 16'h0000, 32'h40, 32'h0);        // R10 load into r0
    run_op(6'h1E, 5'd9, 16'h0004, 32'h40, 32'h0);        // R3 misaligned quad load
    run_op(6'h1F, 5'd3, 16'h0000, 32'h80, 32'hDEADBEEF); // R7 aligned quad store
    run_op(6'h1F, 5'd3, 16'h0008, 32'h80, 32'h12345678); // R2 quad store at 8 mod 16
    run_op(6'h3F, 5'd3, 16'h0008, 32'h80, 32'hCAFEF00D); // R8 doubleword at 8 mod 16
    run_op(6'h3F, 5'd3, 16'h0004, 32'h80, 32'h0);        // R2 misaligned doubleword
    run_op(6'h2B, 5'd3, 16'h0002, 32'h80, 32'h0);        // R3 misaligned word store
    run_op(6'h08, 5'd3, 16'h0000, 32'h80, 32'h0);        // R12 unknown opcode

    for (int n = 0; n < 300; n++) begin
      logic [5:0] ops [6] = '{6'h23, 6'h2B, 6'h1E, 6'h1F, 6'h3F, 6'h0D};
      logic [5:0] op = ops[$urandom % 6];
      logic [31:0] base = $urandom % 192;
      logic [15:0] imm = 16'($signed($urandom % 64) - 16);
      if (($urandom % 3) != 0) begin
        base = base & ~align_mask(op);
        imm  = imm & ~16'(align_mask(op));
      end
      run_op(op, 5'($urandom % 8), imm, base, $urandom);
    end

    chk(n_conflict == 0, "R9", "ready low while busy", n_conflict, 0);
    chk(n_hold_err == 0, "R11", "request held while stalled", n_hold_err, 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule